// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block is the host side of a chain of serial analog-to-digital converters whose shift registers are wired end to end. It drives one conversion-start line and one serial clock that are shared by every converter, holds the serial input of the first converter at logic low, and listens to the serial output of the last converter. A single start request launches a conversion in every device at once. The controller waits out the worst-case conversion time and then clocks the whole chain through, 16 bits per device.

The bit stream reaches the host with the word of the device farthest from the chain head first, and the head device's word last. The controller cuts the stream into 16-bit words and tags each one with the chain position of the converter that produced it, so that position 0 is the head device. When the last word has been delivered, a done pulse ends the burst. Start requests arrive before the minimum conversion period has elapsed, or while a burst is running, and these are dropped.

Top module: `daisy_rd_ctrl`

## Requirements
- R1: After reset, the conversion-start output, the serial clock, busy, word valid and done are all low.
- R2: A conversion-start rising edge happens only in the cycle after start_i is sampled high while the controller is idle. chain_din_o is always driven low.
- R3: The serial clock is low when conversion-start rises. Its first rising edge comes no earlier than CONV_CYC cycles after that rise.
- R4: Conversion-start stays high from its rising edge until the final serial clock falling edge of the burst. The serial clock is never high while conversion-start is low.
- R5: A burst has exactly 16×NUM_DEV serial clock rising edges and the same number of falling edges. Every high level of the serial clock lasts HALF_CYC cycles.
- R6: Serial data are sampled when the serial clock rises, MSB first. The first bit taken is the one present on sdo_i before any clock edge of the burst.
- R7: Each burst gives NUM_DEV single-cycle word_valid_o pulses. The k-th word (k from 0) carries word_idx_o = NUM_DEV−1−k, and so it holds the 16-bit value of chain position NUM_DEV−1−k.
- R8: done_o pulses for one cycle in the same cycle that conversion-start falls. This comes after the last word of the burst.
- R9: start_i is ignored while busy and until PERIOD_CYC cycles have passed since the last accepted start. An ignored request is not remembered. When start_i is held high, the next conversion starts exactly PERIOD_CYC cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to start a conversion and readout burst |
| sdo_i | input | 1 | Serial data from the last converter in the chain |
| cnv_o | output | 1 | Shared conversion-start line |
| sclk_o | output | 1 | Shared serial clock |
| chain_din_o | output | 1 | Serial input of the first converter, held low |
| busy_o | output | 1 | A burst is in progress |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_data_o | output | WORD_W | Completed word, MSB first as received |
| word_idx_o | output | IDX_W | Chain position of the device that produced the word |
| done_o | output | 1 | One-cycle pulse after the last word of a burst |

## Verification
The bench models every converter as a 16-bit shift register that loads a chosen sample partway through the conversion and shifts on the falling edge of the serial clock. It then predicts the exact word sequence, so a controller that samples on the wrong edge, drops the first bit already on the line, or stops one edge short would deliver shifted or truncated words. Patterns of all zeros, all ones, alternating bits and distinct per-device values expose index reversal errors: a design that numbers words in arrival order would tag the head device's value with the wrong position. Start requests given in the middle of a burst and directly after one check that no burst is retriggered or queued. A start held high checks that the conversion period is enforced to the exact cycle.

// File: rtl/daisy_rd_pkg.sv
package daisy_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_LOW,
    ST_HIGH
  } rd_state_e;
endpackage

// File: rtl/daisy_rd_timer.sv
module daisy_rd_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/daisy_rd_deser.sv
module daisy_rd_deser #(
  parameter int NUM_DEV = 4,
  parameter int WORD_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              sdi,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              burst_end
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NUM_DEV - 1);

  logic [BIT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  word_cnt;
  logic [WORD_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      word_cnt   <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_idx   <= '0;
      burst_end  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (clear) begin
        bit_cnt   <= '0;
        word_cnt  <= '0;
        burst_end <= 1'b0;
      end else if (shift_en) begin
        if (bit_cnt == LAST_BIT) begin
          word_valid <= 1'b1;
          word_data  <= {shreg, sdi};
          word_idx   <= TOP_IDX - word_cnt;
          bit_cnt    <= '0;
          if (word_cnt == TOP_IDX) burst_end <= 1'b1;
          else                     word_cnt  <= word_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[WORD_W-3:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/daisy_rd_ctrl.sv
module daisy_rd_ctrl
  import daisy_rd_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int WORD_W     = 16,
  parameter int CONV_CYC   = 1760,
  parameter int PERIOD_CYC = 2000,
  parameter int HALF_CYC   = 4,
  localparam int IDX_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic              chain_din_o,
  output logic              busy_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              done_o
);
  localparam int TMR_W = $clog2(CONV_CYC + PERIOD_CYC + HALF_CYC + 1);
  localparam logic [TMR_W-1:0] CONV_LD = TMR_W'(CONV_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] PER_LD  = TMR_W'(PERIOD_CYC - 1);

  rd_state_e         state;
  logic              ph_load, ph_exp, per_load, per_exp;
  logic [TMR_W-1:0]  ph_val;
  logic              accept, shift_en, burst_end;

  daisy_rd_timer #(.W(TMR_W)) phase_tmr_i (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .expired(ph_exp)
  );

  daisy_rd_timer #(.W(TMR_W)) period_tmr_i (
    .clk(clk), .rst(rst), .load(per_load), .load_val(PER_LD), .expired(per_exp)
  );

  daisy_rd_deser #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .IDX_W(IDX_W)) deser_i (
    .clk(clk), .rst(rst), .clear(accept), .shift_en(shift_en), .sdi(sdo_i),
    .word_valid(word_valid_o), .word_data(word_data_o), .word_idx(word_idx_o),
    .burst_end(burst_end)
  );

  always_comb begin
    accept   = 1'b0;
    shift_en = 1'b0;
    ph_load  = 1'b0;
    ph_val   = HALF_LD;
    per_load = 1'b0;
    case (state)
      ST_IDLE: if (start_i && per_exp) begin
        accept   = 1'b1;
        per_load = 1'b1;
        ph_load  = 1'b1;
        ph_val   = CONV_LD;
      end
      ST_CONV: ph_load = ph_exp;
      ST_LOW: begin
        ph_load  = ph_exp;
        shift_en = ph_exp;
      end
      ST_HIGH: ph_load = ph_exp && !burst_end;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnv_o  <= 1'b0;
      sclk_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          cnv_o <= 1'b1;
          state <= ST_CONV;
        end
        ST_CONV: if (ph_exp) state <= ST_LOW;
        ST_LOW: if (ph_exp) begin
          sclk_o <= 1'b1;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (ph_exp) begin
          sclk_o <= 1'b0;
          if (burst_end) begin
            cnv_o  <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_LOW;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign chain_din_o = 1'b0;
endmodule

// File: rtl/daisy_rd_chk.sv
module daisy_rd_chk #(
  parameter int NUM_DEV  = 4,
  parameter int WORD_W   = 16,
  parameter int CONV_CYC = 1760
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic cnv_o,
  input logic sclk_o,
  input logic busy_o,
  input logic word_valid_o,
  input logic done_o
);
  localparam int TOTAL = WORD_W * NUM_DEV;
  localparam int CW    = $clog2(TOTAL + CONV_CYC + 2) + 1;

  logic          cnv_q, sclk_q;
  logic [CW-1:0] rise_cnt, since_cnv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_q     <= 1'b0;
      sclk_q    <= 1'b0;
      rise_cnt  <= '0;
      since_cnv <= '0;
    end else begin
      cnv_q  <= cnv_o;
      sclk_q <= sclk_o;
      if (cnv_o && !cnv_q) begin
        rise_cnt  <= '0;
        since_cnv <= CW'(1);
      end else begin
        if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
        if (cnv_o && since_cnv != '1) since_cnv <= since_cnv + 1'b1;
      end
    end
  end

  AST_CNV_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> $past(start_i) && $past(!busy_o)); // R2
  AST_SCLK_LOW_AT_CNV: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_o) |-> !sclk_o); // R3
  AST_CONV_WAIT: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && !sclk_q && rise_cnt == '0) |-> since_cnv >= CW'(CONV_CYC)); // R3
  AST_SCLK_INSIDE_CNV: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> cnv_o); // R4
  AST_EDGE_TOTAL: assert property (@(posedge clk) disable iff (rst)
    (cnv_q && !cnv_o) |-> rise_cnt == CW'(TOTAL)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o); // R7
  AST_VALID_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> sclk_o); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_o) |-> done_o); // R8
  AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cnv_o && cnv_q); // R8
endmodule

bind daisy_rd_ctrl daisy_rd_chk #(
  .NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .CONV_CYC(CONV_CYC)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .cnv_o(cnv_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .word_valid_o(word_valid_o), .done_o(done_o)
);

// File: tb/daisy_rd_ctrl_tb.sv
`timescale 1ns/1ps
module daisy_rd_ctrl_tb_top;
  localparam int N      = 4;
  localparam int W      = 16;
  localparam int CONV   = 1760;
  localparam int PERIOD = 2400;
  localparam int HALF   = 3;
  localparam int IW     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sdo_i;
  logic cnv_o, sclk_o, chain_din_o, busy_o, word_valid_o, done_o;
  logic [W-1:0] word_data_o;
  logic [IW-1:0] word_idx_o;

  always #2.5 clk = ~clk;

  daisy_rd_ctrl #(.NUM_DEV(N), .WORD_W(W), .CONV_CYC(CONV), .PERIOD_CYC(PERIOD),
                  .HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_i), .cnv_o(cnv_o),
    .sclk_o(sclk_o), .chain_din_o(chain_din_o), .busy_o(busy_o),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o),
    .word_idx_o(word_idx_o), .done_o(done_o));

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter chain model
  logic [W-1:0] samp [N];
  logic [W-1:0] dev  [N];
  int exp_idx[$];
  logic [W-1:0] exp_dat[$];
  assign sdo_i = dev[N-1][W-1];

  initial for (int i = 0; i < N; i++) dev[i] = '0;

  always @(posedge cnv_o) begin
    if (chain_din_o === 1'b0) begin
      fork
        begin
          #4000;
          for (int i = 0; i < N; i++) dev[i] = samp[i];
          for (int k = 0; k < N; k++) begin
            exp_idx.push_back(N - 1 - k);
            exp_dat.push_back(samp[N - 1 - k]);
          end
        end
      join_none
    end
  end

  always @(negedge sclk_o) begin
    for (int i = N - 1; i > 0; i--) dev[i] = {dev[i][W-2:0], dev[i-1][W-1]};
    dev[0] = {dev[0][W-2:0], chain_din_o};
  end

  // per-cycle monitor
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic cnv_q = 1'b0, sclk_q = 1'b0;
  int rises = 0, falls = 0, hi_run = 0, bursts = 0;
  longint cnv_rise_cyc = 0, prev_rise_cyc = -1, last_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(chain_din_o == 1'b0, "R2", "chain head level", chain_din_o, 0);
      if (cnv_o && !cnv_q) begin
        bursts++;
        chk(sclk_o == 1'b0, "R3", "sclk at cnv rise", sclk_o, 0);
        if (prev_rise_cyc >= 0) last_gap = cyc - prev_rise_cyc;
        prev_rise_cyc = cyc;
        cnv_rise_cyc = cyc;
        rises = 0; falls = 0;
      end
      if (sclk_o) begin
        chk(cnv_o == 1'b1, "R4", "cnv during sclk high", cnv_o, 1);
        hi_run++;
      end
      if (sclk_o && !sclk_q) begin
        rises++;
        if (rises == 1)
          chk(cyc - cnv_rise_cyc >= CONV, "R3", "conversion wait",
              cyc - cnv_rise_cyc, CONV);
      end
      if (!sclk_o && sclk_q) begin
        falls++;
        chk(hi_run == HALF, "R5", "sclk high length", hi_run, HALF);
        hi_run = 0;
      end
      if (!cnv_o && cnv_q) begin
        chk(rises == W * N, "R5", "rising edges", rises, W * N);
        chk(falls == W * N, "R4", "falls before cnv drop", falls, W * N);
        chk(done_o == 1'b1, "R8", "done at cnv fall", done_o, 1);
        chk(exp_idx.size() == 0, "R7", "words left", exp_idx.size(), 0);
      end else begin
        chk(done_o == 1'b0, "R8", "done outside end", done_o, 0);
      end
      if (word_valid_o) begin
        if (exp_idx.size() == 0) begin
          chk(1'b0, "R7", "unexpected word", word_data_o, 0);
        end else begin
          chk(word_idx_o == exp_idx[0], "R7", "word index", word_idx_o, exp_idx[0]);
          chk(word_data_o == exp_dat[0], "R6", "word data", word_data_o, exp_dat[0]);
          void'(exp_idx.pop_front());
          void'(exp_dat.pop_front());
        end
      end
      cnv_q = cnv_o;
      sclk_q = sclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic burst(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d);
    samp[0] = a; samp[1] = b; samp[2] = c; samp[3] = d;
    wait (!busy_o && dut_i.period_tmr_i.expired === 1'b1);
    pulse_start();
    @(posedge done_o);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < N; i++) samp[i] = '0;
    repeat (5) @(negedge clk);
    chk(cnv_o == 0 && sclk_o == 0, "R1", "reset lines", {cnv_o, sclk_o}, 0);
    chk(busy_o == 0 && word_valid_o == 0 && done_o == 0, "R1", "reset flags",
        {busy_o, word_valid_o, done_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnv_o == 0, "R2", "no start without request", cnv_o, 0);

    burst(16'h1234, 16'hABCD, 16'h5A5A, 16'hF00F);   // R6 R7 distinct values
    burst(16'h0000, 16'h0000, 16'h0000, 16'h0000);
    burst(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    burst(16'hAAAA, 16'h5555, 16'h0001, 16'h8000);

    // R9: request mid-burst and right after completion is dropped
    samp[0] = 16'h0F0F; samp[1] = 16'h00FF; samp[2] = 16'hC3C3; samp[3] = 16'h7E81;
    wait (!busy_o && dut_i.period_tmr_i.expired === 1'b1);
    pulse_start();
    repeat (500) @(negedge clk);
    pulse_start();
    @(posedge done_o);
    pulse_start();
    repeat (100) @(negedge clk);
    chk(bursts == 5, "R9", "bursts after ignored requests", bursts, 5);
    chk(cnv_o == 0, "R9", "no queued restart", cnv_o, 0);

    // R9: held request restarts exactly one period after the previous start
    samp[0] = 16'h1111; samp[1] = 16'h2222; samp[2] = 16'h3333; samp[3] = 16'h4444;
    @(negedge clk) start_i = 1'b1;
    @(posedge cnv_o);
    @(negedge clk) start_i = 1'b0;
    @(negedge clk);
    chk(last_gap == PERIOD, "R9", "period gap", last_gap, PERIOD);
    @(posedge done_o);
    repeat (3) @(negedge clk);
    chk(bursts == 6, "R2", "burst count", bursts, 6);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule